// File: doc/BRIEF.md
# Byte Block Move Engine

This engine copies a run of bytes from one memory region to another. A host sequencer gives it three values with a single start pulse: a byte count, a starting source pointer and a starting destination pointer. A per-transfer mode bit chooses how the count is read. In wide mode all 16 count bits are used. In narrow mode only the low 8 bits are used. If the selected count is zero at start, the transfer is a no-op that completes at once.

For each byte, the engine issues a read at the source address and waits for the memory to answer with a valid strobe. It then writes the returned byte to the destination address for one cycle. Both pointers step up by one, and the selected count steps down by one. When the count reaches zero, the engine raises a one-cycle done pulse. The final count and pointers remain on output ports so the host can write them back into its register file.

Addresses are 24 bits wide. They are carried in 32-bit pointers whose top byte is always zero.

Top module: `blkmove_engine`

## Requirements
- R1: With `wide_i`=1 the byte count is all 16 bits of `count_i`. With `wide_i`=0 it is `count_i[7:0]` only, so `count_i`=16'h0100 moves 256 bytes in wide mode and none in narrow mode.
- R2: If the selected count is zero at start, no read and no write is issued. `done_o` is high in the cycle after the start cycle, and `busy_o` never rises.
- R3: Byte k of a transfer is read from source start + k and written to destination start + k. The written data equals the data that was read, and writes occur in ascending order.
- R4: `mem_rd_o` stays high until a cycle in which `mem_rvalid_i` is high. `mem_we_o` is then high for exactly one cycle. `mem_rd_o` and `mem_we_o` are never high together.
- R5: Pointers wrap modulo 2^24. Bits 31:24 of `src_o` and `dst_o` are always zero, whatever bits 31:24 of `src_i` and `dst_i` hold.
- R6: `done_o` is a one-cycle pulse in the cycle right after the last write. In that cycle `src_o` and `dst_o` hold start + N (mod 2^24) and the selected count bits of `count_o` are zero.
- R7: In narrow mode, `count_o[15:8]` at done equals `count_i[15:8]` from the start cycle.
- R8: `busy_o` is high from the cycle after an accepted nonzero start until done, and it is low in the done cycle. A start while busy is ignored.
- R9: Synchronous active-high reset sets `busy_o`, `done_o`, `mem_rd_o`, `mem_we_o` and `count_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| wide_i | input | 1 | 1: 16-bit count, 0: 8-bit count |
| count_i | input | 16 | Byte count |
| src_i | input | 32 | Starting source pointer |
| dst_i | input | 32 | Starting destination pointer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| count_o | output | 16 | Current/final count |
| src_o | output | 32 | Current/final source pointer |
| dst_o | output | 32 | Current/final destination pointer |
| mem_rd_o | output | 1 | Read request |
| mem_raddr_o | output | 24 | Read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data |
| mem_we_o | output | 1 | Write enable, one cycle per byte |
| mem_waddr_o | output | 24 | Write address |
| mem_wdata_o | output | 8 | Write data |

## Verification
A corrupted pointer shows up within one byte as a wrong address on the memory port. It also leaves a wrong final pointer on `src_o` or `dst_o` in the done cycle. A count that is decremented wrongly changes the number of writes and moves the done pulse, or in narrow mode it disturbs `count_o[15:8]`. A state register that accepts a second start or misses the zero-count path changes `busy_o` and the done timing. The zero-count case is caught within one cycle, and a wrong transfer is caught at its end.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } bm_state_t;
endpackage

// File: rtl/blkmove_count.sv
module blkmove_count #(
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             wide_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_zero_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wide_q;

  // Zero test on the live inputs, for the start decision
  assign start_zero_o = wide_i ? (cnt_i == '0) : (cnt_i[NARROW_W-1:0] == '0);
  // Only the selected width decides the last byte
  assign last_o = wide_q ? (cnt_q == CNT_W'(1))
                         : (cnt_q[NARROW_W-1:0] == NARROW_W'(1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wide_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= cnt_i;
      wide_q <= wide_i;
    end else if (dec_i) begin
      if (wide_q) cnt_q <= cnt_q - CNT_W'(1);
      else        cnt_q[NARROW_W-1:0] <= cnt_q[NARROW_W-1:0] - NARROW_W'(1);
    end
  end

  // R7: narrow decrement leaves the upper byte alone
  a_r7_upper_hold: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !wide_q) |=> (cnt_q[CNT_W-1:NARROW_W] == $past(cnt_q[CNT_W-1:NARROW_W])));
  // R1: never decrement a selected count of zero
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec_i |-> (wide_q ? (cnt_q != '0) : (cnt_q[NARROW_W-1:0] != '0)));
endmodule

// File: rtl/blkmove_ptr.sv
module blkmove_ptr #(
  parameter int PTR_W  = 32,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PTR_W-1:0]  ptr_o
);
  localparam int PAD_W = PTR_W - ADDR_W;

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (load_i) addr_q <= ptr_i[ADDR_W-1:0];
    else if (inc_i)  addr_q <= addr_q + ADDR_W'(1);
  end

  assign addr_o = addr_q;

  generate
    if (PAD_W > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^ptr_i[PTR_W-1:ADDR_W];
      assign ptr_o = {{PAD_W{1'b0}}, addr_q};
    end else begin : g_nopad
      assign ptr_o = addr_q[PTR_W-1:0];
    end
  endgenerate

  // R5: one step per increment, wrapping at the address width
  a_r5_step_wrap: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/blkmove_fsm.sv
module blkmove_fsm
  import blkmove_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic start_zero_i,
  input  logic rvalid_i,
  input  logic last_i,
  output logic load_o,
  output logic rd_o,
  output logic rd_take_o,
  output logic we_o,
  output logic busy_o,
  output logic done_o
);
  bm_state_t state_q, state_d;
  logic      done_q;
  logic      accept;

  assign accept    = start_i && (state_q == ST_IDLE);
  assign load_o    = accept;
  assign rd_o      = (state_q == ST_READ);
  assign rd_take_o = rd_o && rvalid_i;
  assign we_o      = (state_q == ST_WRITE);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept && !start_zero_i) state_d = ST_READ;
      ST_READ:  if (rvalid_i)                state_d = ST_WRITE;
      ST_WRITE: state_d = last_i ? ST_IDLE : ST_READ;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (accept && start_zero_i) || (we_o && last_i);
    end
  end

  a_r4_rd_we_excl: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && we_o));
  a_r4_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_o && !rvalid_i) |=> rd_o);
  a_r4_we_single: assert property (@(posedge clk) disable iff (rst)
    we_o |=> !we_o);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));
  a_r2_zero_done: assert property (@(posedge clk) disable iff (rst)
    (accept && start_zero_i) |=> (done_o && !busy_o));
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8,
  parameter int PTR_W    = 32,
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              wide_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [PTR_W-1:0]  src_i,
  input  logic [PTR_W-1:0]  dst_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [PTR_W-1:0]  src_o,
  output logic [PTR_W-1:0]  dst_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic              load, rd_take, start_zero, last;
  logic [DATA_W-1:0] data_q;

  blkmove_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .start_zero_i (start_zero),
    .rvalid_i     (mem_rvalid_i),
    .last_i       (last),
    .load_o       (load),
    .rd_o         (mem_rd_o),
    .rd_take_o    (rd_take),
    .we_o         (mem_we_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  blkmove_count #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_count (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load),
    .wide_i       (wide_i),
    .cnt_i        (count_i),
    .dec_i        (mem_we_o),
    .cnt_o        (count_o),
    .start_zero_o (start_zero),
    .last_o       (last)
  );

  // Source steps when its byte is taken, destination when its byte is written
  blkmove_ptr #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_src (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .ptr_i  (src_i),
    .inc_i  (rd_take),
    .addr_o (mem_raddr_o),
    .ptr_o  (src_o)
  );

  blkmove_ptr #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_dst (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .ptr_i  (dst_i),
    .inc_i  (mem_we_o),
    .addr_o (mem_waddr_o),
    .ptr_o  (dst_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          data_q <= '0;
    else if (rd_take) data_q <= mem_rdata_i;
  end

  assign mem_wdata_o = data_q;

  // R5: pointer top byte is always clear
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (src_o[PTR_W-1:ADDR_W] == '0) && (dst_o[PTR_W-1:ADDR_W] == '0));
  // R3: each write carries the byte taken in the cycle before
  a_r3_data_carry: assert property (@(posedge clk) disable iff (rst)
    rd_take |=> (mem_we_o && mem_wdata_o == $past(mem_rdata_i)));
endmodule

// File: tb/tb_blkmove_engine.sv
`timescale 1ns/1ps
module tb_blkmove_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, wide_i = 1'b0;
  logic [15:0] count_i = '0;
  logic [31:0] src_i = '0, dst_i = '0;
  logic        busy_o, done_o, mem_rd_o, mem_we_o;
  logic [15:0] count_o;
  logic [31:0] src_o, dst_o;
  logic [23:0] mem_raddr_o, mem_waddr_o;
  logic        mem_rvalid_i;
  logic [7:0]  mem_rdata_i, mem_wdata_o;

  int n_chk = 0, n_err = 0;
  int lat = 0, wait_c = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [23:0] wlog_a [512];
  logic [7:0]  wlog_d [512];

  always #4 clk = ~clk;

  blkmove_engine dut (
    .clk(clk), .rst(rst), .start_i(start_i), .wide_i(wide_i), .count_i(count_i),
    .src_i(src_i), .dst_i(dst_i), .busy_o(busy_o), .done_o(done_o),
    .count_o(count_o), .src_o(src_o), .dst_o(dst_o), .mem_rd_o(mem_rd_o),
    .mem_raddr_o(mem_raddr_o), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .mem_we_o(mem_we_o), .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // Memory model: read data is a function of the address, writes are logged
  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid_i <= 1'b0;
      mem_rdata_i  <= '0;
      wait_c       <= 0;
    end else begin
      mem_rvalid_i <= 1'b0;
      if (mem_rd_o && !mem_rvalid_i) begin
        if (wait_c >= lat) begin
          mem_rvalid_i <= 1'b1;
          mem_rdata_i  <= pat(mem_raddr_o);
          wait_c       <= 0;
          rd_cnt       <= rd_cnt + 1;
        end else wait_c <= wait_c + 1;
      end
      if (mem_we_o) begin
        wlog_a[wr_cnt & 511] <= mem_waddr_o;
        wlog_d[wr_cnt & 511] <= mem_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wide, input logic [15:0] cnt, input logic [31:0] src,
                      input logic [31:0] dst, input int l, input bit poke);
    int n, cyc, base_w, base_r, bad;
    bit busy_bad, prev_we, rd_we_both;
    logic [23:0] s24, d24;
    n = wide ? int'(cnt) : int'(cnt[7:0]);
    s24 = src[23:0]; d24 = dst[23:0];
    lat = l;
    base_w = wr_cnt; base_r = rd_cnt;
    @(negedge clk);
    start_i = 1'b1; wide_i = wide; count_i = cnt; src_i = src; dst_i = dst;
    @(negedge clk);
    start_i = 1'b0; wide_i = ~wide; count_i = 16'h0000; src_i = 32'h0; dst_i = 32'h0;
    cyc = 0; busy_bad = 0; prev_we = 0; rd_we_both = 0;
    while (!done_o && cyc < 5000) begin
      if (!busy_o) busy_bad = 1;
      if (mem_rd_o && mem_we_o) rd_we_both = 1;
      if (poke && cyc == 4) begin
        start_i = 1'b1; wide_i = 1'b1; count_i = 16'h0000;
        src_i = 32'h0000_0700; dst_i = 32'h0000_0900;
      end else start_i = 1'b0;
      prev_we = mem_we_o;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(done_o, "R6 done reached", {31'b0, done_o}, 32'h1);
    chk(!busy_bad, "R8 busy held until done", {31'b0, busy_bad}, 32'h0);
    chk(!busy_o, "R8 busy low at done", {31'b0, busy_o}, 32'h0);
    chk(!rd_we_both, "R4 rd/we exclusive", {31'b0, rd_we_both}, 32'h0);
    chk(wr_cnt - base_w == n, "R3 write count", wr_cnt - base_w, n);
    chk(rd_cnt - base_r == n, "R3 read count", rd_cnt - base_r, n);
    if (n == 0) chk(cyc == 0, "R2 done one cycle after start", cyc, 0);
    else        chk(prev_we, "R6 done right after last write", {31'b0, prev_we}, 32'h1);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      if (wlog_a[(base_w + k) & 511] != d24 + 24'(k) ||
          wlog_d[(base_w + k) & 511] != pat(s24 + 24'(k))) bad++;
    end
    chk(bad == 0, "R3 addresses and data", bad, 0);
    chk(count_o == (wide ? 16'h0 : {cnt[15:8], 8'h00}), "R7 final count", count_o,
        wide ? 16'h0 : {cnt[15:8], 8'h00});
    chk(src_o == {8'h00, s24 + 24'(n)}, "R5 final source", src_o, {8'h00, s24 + 24'(n)});
    chk(dst_o == {8'h00, d24 + 24'(n)}, "R5 final destination", dst_o, {8'h00, d24 + 24'(n)});
    @(negedge clk);
    chk(!done_o, "R6 done single pulse", {31'b0, done_o}, 32'h0);
  endtask

  task automatic t_reset;
    chk(!busy_o && !done_o, "R9 busy/done reset", {30'b0, busy_o, done_o}, 32'h0);
    chk(!mem_rd_o && !mem_we_o, "R9 rd/we reset", {30'b0, mem_rd_o, mem_we_o}, 32'h0);
    chk(count_o == 16'h0, "R9 count reset", count_o, 32'h0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%0d expected=<150000", wd);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    xfer(1'b1, 16'd5, 32'h0000_1000, 32'h0000_2000, 0, 1'b0);   // R1 wide, R3
    xfer(1'b0, 16'hA703, 32'h0000_1100, 32'h0000_2100, 1, 1'b0); // R1 narrow, R7
    xfer(1'b1, 16'h0100, 32'h0000_0000, 32'h0000_0400, 0, 1'b0); // R1 256 bytes
    xfer(1'b0, 16'h0500, 32'h0000_3000, 32'h0000_3100, 0, 1'b0); // R2 narrow zero
    xfer(1'b1, 16'h0000, 32'h0012_0000, 32'h0034_0000, 0, 1'b0); // R2 wide zero
    xfer(1'b1, 16'd4, 32'hABFF_FFFE, 32'hCD00_0FFF, 0, 1'b0);    // R5 wrap, upper bits
    xfer(1'b1, 16'd6, 32'h0000_0A00, 32'h0000_0B00, 3, 1'b1);    // R4 slow memory, R8 poke
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule